// File: doc/BRIEF.md
# Ring-to-Idle Transition Sequencer

This controller sits on the host side of a line card. It takes a subscriber line switch out of power ringing and into the idle/talk condition. A one-cycle start request launches the hand-over. The method is chosen when the request is accepted:

- **Make-before-break:** the line contacts close while the ringing contact is still waiting for its zero-current release.
- **Break-before-make, code path:** a timed all-off code sits between ringing and idle.
- **Break-before-make, override path:** the device's shutdown line is held low for a timed window while the three control levels move from ringing to idle underneath it.

The switch device and the ringing source lie outside this block. It only produces three select levels, a pull-low enable for the override line, and a one-cycle completion pulse. The override line is open-drain in use. The block can only pull it low or let it go, because a driven high level would switch off the device's thermal protection.

Timed intervals are counted in ticks. A tick is `CLKS_PER_TICK` clock cycles, which is one millisecond at the intended clock. The hold length is taken from `hold_ticks` when a request is accepted. A value of zero picks the default of `DEFAULT_HOLD` ticks (25).

Top module: `ring_idle_seq`

## Requirements
- R1: After reset, the select code {sel_ring, sel_tin, sel_tout} is 101 (all-off), ovr_pull_low is 0 (released) and done is 0. This holds until a start is accepted.
- R2: When mode 0 (make-before-break) is accepted at edge k, the code is 100 for the one cycle after edge k. It is 000 from edge k+1 onward.
- R3: When mode 1 (break-before-make by code) is accepted at edge k, the code is 100 for one cycle. It is then 101 for exactly N·CLKS_PER_TICK cycles, and then 000.
- R4: When mode 2 (break-before-make by override) is accepted at edge k, the code is 100 for one cycle. Then ovr_pull_low is 1 for exactly N·CLKS_PER_TICK cycles. The code is 100 in the first of those cycles and 000 in the rest. After that ovr_pull_low returns to 0 with the code at 000.
- R5: ovr_pull_low is 1 only inside a mode-2 window. The block has no way to drive the override line high.
- R6: N is hold_ticks as sampled at the accepting edge. A value of 0 selects DEFAULT_HOLD (25). Later changes to hold_ticks have no effect on a running sequence.
- R7: done is high for exactly one cycle, in the first cycle in which the code reaches 000 at the end of a sequence.
- R8: A start that arrives while a sequence is in progress is ignored, together with its mode and hold_ticks.
- R9: Mode 3 behaves exactly as mode 1.
- R10: A start is accepted both from the post-reset all-off condition and from idle (code 000). From idle the code returns to 100 in the cycle after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin the ring-to-idle hand-over |
| mode | input | 2 | Method: 0 make-before-break, 1 or 3 break-before-make by code, 2 break-before-make by override |
| hold_ticks | input | HOLD_W | Hold length in ticks; 0 selects the default |
| sel_ring | output | 1 | Ringing select level (first bit of the code) |
| sel_tin | output | 1 | Test-in select level (second bit of the code) |
| sel_tout | output | 1 | Test-out select level (third bit of the code) |
| ovr_pull_low | output | 1 | 1 = pull the override line low, 0 = release it |
| done | output | 1 | One-cycle pulse when idle is reached |

## Verification
A state register stuck or mis-coded shows at the select pins in the cycle right after the edge where it happens. The select pins decode the state with no further delay. Errors in the tick prescaler or the hold counter change the length of the all-off or override window by whole cycles. They show up at the exact cycle where the window should close, either as an early 000 or as a late one. A mode or hold value latched at the wrong time changes the shape of the whole next sequence. A busy-start error shows as a second 100 in the middle of a window.

// File: rtl/rtis_pkg.sv
// Shared types for the ring-to-idle sequencer.
// Assumes: select code bit order is {ring, tin, tout}.
package rtis_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RING = 3'd1,
        ST_HOLD = 3'd2,
        ST_OVR  = 3'd3,
        ST_IDLE = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_MBB     = 2'd0,
        MD_BBM_IN  = 2'd1,
        MD_BBM_OVR = 2'd2,
        MD_ALT     = 2'd3
    } method_e;

    typedef struct packed {
        logic ring;
        logic tin;
        logic tout;
    } sel_t;

    localparam sel_t SEL_RINGING = '{ring: 1'b1, tin: 1'b0, tout: 1'b0};
    localparam sel_t SEL_ALLOFF  = '{ring: 1'b1, tin: 1'b0, tout: 1'b1};
    localparam sel_t SEL_IDLE    = '{ring: 1'b0, tin: 1'b0, tout: 1'b0};

endpackage

// File: rtl/rtis_window.sv
// Timed window counter: counts whole ticks while 'run' is high.
// A tick is CLKS_PER_TICK clocks. The prescaler restarts on each window,
// so a window lasts exactly limit*CLKS_PER_TICK cycles.
// Assumes: limit >= 1, CLKS_PER_TICK >= 2, run stays high until expire.
module rtis_window #(
    parameter int CLKS_PER_TICK = 125000,
    parameter int CNT_W         = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             first,
    output logic             expire
);
    localparam int PRE_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);

    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] tcnt_q;
    logic             tick;

    assign tick   = (pre_q == PRE_LAST);
    assign expire = run && tick && (tcnt_q == limit - CNT_W'(1));
    assign first  = run && (pre_q == '0) && (tcnt_q == '0);

    // Prescaler and tick counter, cleared whenever no window is open.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_q  <= '0;
            tcnt_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            tcnt_q <= tcnt_q + CNT_W'(1);
        end else begin
            pre_q  <= pre_q + PRE_W'(1);
        end
    end

    // R3
    window_no_instant_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> !expire);

    // R4
    window_first_only_at_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> !first);

endmodule

// File: rtl/rtis_ctrl.sv
// Sequence controller: accepts a start when not busy, latches the method
// and hold length, and walks ringing -> (hold | override window) -> idle.
// Assumes: window expiry comes from rtis_window, driven by 'run'.
module rtis_ctrl
    import rtis_pkg::*;
#(
    parameter int HOLD_W       = 8,
    parameter int DEFAULT_HOLD = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [HOLD_W-1:0] hold_ticks,
    input  logic              win_first,
    input  logic              win_expire,
    output logic              win_run,
    output logic [HOLD_W-1:0] win_limit,
    output sel_t              sel,
    output logic              ovr_low,
    output logic              done
);
    localparam logic [HOLD_W-1:0] DEF_HOLD = HOLD_W'(DEFAULT_HOLD);

    seq_state_e        state_q, state_d;
    method_e           mode_q;
    logic [HOLD_W-1:0] limit_q;
    logic              done_q;
    logic              accept;
    logic              busy;

    assign busy   = (state_q == ST_RING) || (state_q == ST_HOLD) || (state_q == ST_OVR);
    assign accept = start && !busy;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_OFF, ST_IDLE: if (accept) state_d = ST_RING;
            ST_RING: begin
                case (mode_q)
                    MD_MBB:     state_d = ST_IDLE;
                    MD_BBM_OVR: state_d = ST_OVR;
                    default:    state_d = ST_HOLD;
                endcase
            end
            ST_HOLD, ST_OVR: if (win_expire) state_d = ST_IDLE;
            default: state_d = ST_OFF;
        endcase
    end

    // State, latched request fields and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            mode_q  <= MD_MBB;
            limit_q <= DEF_HOLD;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_d == ST_IDLE) && (state_q != ST_IDLE);
            if (accept) begin
                mode_q  <= method_e'(mode);
                limit_q <= (hold_ticks == '0) ? DEF_HOLD : hold_ticks;
            end
        end
    end

    // Output decode from the current state.
    always_comb begin
        sel     = SEL_ALLOFF;
        ovr_low = 1'b0;
        case (state_q)
            ST_RING: sel = SEL_RINGING;
            ST_HOLD: sel = SEL_ALLOFF;
            ST_OVR: begin
                sel     = win_first ? SEL_RINGING : SEL_IDLE;
                ovr_low = 1'b1;
            end
            ST_IDLE: sel = SEL_IDLE;
            default: sel = SEL_ALLOFF;
        endcase
    end

    assign win_run   = (state_q == ST_HOLD) || (state_q == ST_OVR);
    assign win_limit = limit_q;
    assign done      = done_q;

    // R1
    reset_alloff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel == SEL_ALLOFF && !ovr_low && !done));

    // R7
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sel == SEL_IDLE && !ovr_low));

    // R4
    ovr_release_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_low) |-> (sel == SEL_IDLE && done));

    // R5
    ovr_only_in_mode2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_low |-> (mode_q == MD_BBM_OVR));

    // R8
    busy_holds_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode_q) && $stable(limit_q)));

endmodule

// File: rtl/ring_idle_seq.sv
// Ring-to-idle transition sequencer top: controller plus timed window.
// Outputs are the three select levels, an open-drain style override
// pull-low enable (never a high drive), and a completion pulse.
// Assumes: CLKS_PER_TICK >= 2; one tick is the intended millisecond.
module ring_idle_seq #(
    parameter int CLKS_PER_TICK = 125000,
    parameter int HOLD_W        = 8,
    parameter int DEFAULT_HOLD  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [HOLD_W-1:0] hold_ticks,
    output logic              sel_ring,
    output logic              sel_tin,
    output logic              sel_tout,
    output logic              ovr_pull_low,
    output logic              done
);
    import rtis_pkg::*;

    sel_t              sel;
    logic              win_run;
    logic              win_first;
    logic              win_expire;
    logic [HOLD_W-1:0] win_limit;

    rtis_ctrl #(
        .HOLD_W       (HOLD_W),
        .DEFAULT_HOLD (DEFAULT_HOLD)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .mode       (mode),
        .hold_ticks (hold_ticks),
        .win_first  (win_first),
        .win_expire (win_expire),
        .win_run    (win_run),
        .win_limit  (win_limit),
        .sel        (sel),
        .ovr_low    (ovr_pull_low),
        .done       (done)
    );

    rtis_window #(
        .CLKS_PER_TICK (CLKS_PER_TICK),
        .CNT_W         (HOLD_W)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (win_run),
        .limit  (win_limit),
        .first  (win_first),
        .expire (win_expire)
    );

    assign sel_ring = sel.ring;
    assign sel_tin  = sel.tin;
    assign sel_tout = sel.tout;

endmodule

// File: tb/sim_ring_idle_seq.sv
// Bench: a queue of expected output cycles is filled on each accepted
// start and popped each clock, then compared at the falling edge.
module sim_ring_idle_seq;
    localparam int CPT = 4;
    localparam int HW  = 8;
    localparam int DEF = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [HW-1:0] hold_ticks = '0;
    logic          sel_ring, sel_tin, sel_tout, ovr_pull_low, done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    ring_idle_seq #(.CLKS_PER_TICK(CPT), .HOLD_W(HW), .DEFAULT_HOLD(DEF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .hold_ticks(hold_ticks), .sel_ring(sel_ring), .sel_tin(sel_tin),
        .sel_tout(sel_tout), .ovr_pull_low(ovr_pull_low), .done(done)
    );

    typedef struct {
        logic [2:0] code;
        bit         ovr;
        bit         dn;
        string      tag;
    } item_t;

    item_t q[$];
    item_t cur;

    function automatic item_t mk(logic [2:0] c, bit o, bit d, string t);
        item_t it;
        it.code = c; it.ovr = o; it.dn = d; it.tag = t;
        return it;
    endfunction

    // Reference model: on acceptance, enqueue the full expected sequence.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            cur = mk(3'b101, 0, 0, "R1");
        end else begin
            if (start && q.size() == 0) begin
                int n;
                n = (hold_ticks == 0) ? DEF : int'(hold_ticks);
                if (mode == 2'd0) begin
                    q.push_back(mk(3'b100, 0, 0, "R2"));
                    q.push_back(mk(3'b000, 0, 1, "R2"));
                end else if (mode == 2'd2) begin
                    q.push_back(mk(3'b100, 0, 0, "R4"));
                    q.push_back(mk(3'b100, 1, 0, "R4"));
                    for (int i = 1; i < n * CPT; i++) q.push_back(mk(3'b000, 1, 0, "R4"));
                    q.push_back(mk(3'b000, 0, 1, "R7"));
                end else begin
                    q.push_back(mk(3'b100, 0, 0, (mode == 2'd3) ? "R9" : "R3"));
                    for (int i = 0; i < n * CPT; i++) q.push_back(mk(3'b101, 0, 0, "R6"));
                    q.push_back(mk(3'b000, 0, 1, "R3"));
                end
            end
            if (q.size() > 0) cur = q.pop_front();
            else cur = mk(cur.code, cur.ovr, 0, (cur.code == 3'b000) ? "R8" : "R1");
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            checks++;
            if ({sel_ring, sel_tin, sel_tout} !== cur.code || ovr_pull_low !== cur.ovr
                || done !== cur.dn) begin
                errors++;
                $display("FAIL %s cycle %0d: got code=%b ovr=%b done=%b exp code=%b ovr=%b done=%b",
                         cur.tag, cyc, {sel_ring, sel_tin, sel_tout}, ovr_pull_low, done,
                         cur.code, cur.ovr, cur.dn);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic go(input logic [1:0] m, input int h);
        @(negedge clk); #1;
        start = 1'b1; mode = m; hold_ticks = HW'(h);
        @(negedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_done();
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        idle(4);                       // R1: all-off held after reset
        go(2'd0, 3); wait_done();      // R2, R10 from off
        idle(2);
        go(2'd1, 3); wait_done();      // R3, R10 from idle
        go(2'd2, 2); wait_done();      // R4, R5
        go(2'd1, 0); wait_done();      // R6 default hold
        go(2'd3, 1); wait_done();      // R9
        go(2'd1, 5);                   // R8: busy start ignored
        idle(3);
        @(negedge clk); #1;
        start = 1'b1; mode = 2'd2; hold_ticks = 8'd1;
        @(negedge clk); #1;
        start = 1'b0; hold_ticks = 8'd9;   // R6: change mid-sequence
        wait_done();
        go(2'd2, 1); wait_done();      // R4 minimal window
        idle(3);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule